// File: doc/BRIEF.md
# Four-bit universal shift register

A small register that holds a 4-bit word and, on every rising clock edge, selects its next contents with a 2-bit mode input. The word can be kept as it is, replaced from a 4-bit parallel input, moved one place toward the most significant bit, or moved one place toward the least significant bit. Each shift direction has its own serial input, which fills the bit position left empty by the move.

The current contents appear directly on the parallel output, with no extra register stage. A synchronous active-high clear forces the word to zero and wins over every mode. The block is meant as a building element inside a datapath, for example a small staging register or a serial-to-parallel converter.

Top module: `ushift4`

## Requirements
- R1: While `clr_i` is 1 at a rising edge, the register becomes 0000 on that edge, whatever `mode_i` is.
- R2: With `mode_i` = 2'b00 (hold), the contents are unchanged on the edge.
- R3: With `mode_i` = 2'b01 (load), the contents become `par_i` on the edge (bit 3 to bit 3, down to bit 0). From 0011 with `par_i` = 0101 the result is 0101.
- R4: With `mode_i` = 2'b10 (shift up), the new word is {old[2:0], `up_si`}: bit 3 is dropped and `up_si` enters bit 0. From 0011 with `up_si` = 1 the result is 0111.
- R5: With `mode_i` = 2'b11 (shift down), the new word is {`dn_si`, old[3:1]}: bit 0 is dropped and `dn_si` enters bit 3. From 0011 with `dn_si` = 0 the result is 0001.
- R6: `q_o` shows the current register contents with no added delay, and it changes only on a rising clock edge.
- R7: The serial input of the direction not selected, and `par_i` outside load mode, have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| clr_i | input | 1 | Synchronous clear, active high, highest priority |
| mode_i | input | 2 | 00 hold, 01 load, 10 shift up, 11 shift down |
| par_i | input | 4 | Parallel data for load mode |
| up_si | input | 1 | Serial bit entering bit 0 during shift up |
| dn_si | input | 1 | Serial bit entering bit 3 during shift down |
| q_o | output | 4 | Current register contents |

## Verification
The hardest behaviour to show from the ports is that inputs which are not selected really have no effect, since a wrong connection changes the result only for particular combinations of starting state and idle input values. The stimulus therefore sets every one of the 16 starting states through load mode, then applies each mode with every combination of both serial inputs and a parallel input that differs from the start word, so a mis-wired serial input or a leaking parallel input always changes the result. The clear is applied across all four modes with all inputs active to show that it wins.

// File: rtl/ushift4_pkg.sv
package ushift4_pkg;
    localparam int unsigned WIDTH = 4;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_LOAD = 2'b01,
        MODE_UP   = 2'b10,
        MODE_DOWN = 2'b11
    } mode_e;

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } state_t;
endpackage

// File: rtl/ushift4_next.sv
module ushift4_next
    import ushift4_pkg::*;
#(
    parameter int unsigned W = WIDTH
) (
    input  logic [W-1:0] cur_i,
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] par_i,
    input  logic         up_si,
    input  logic         dn_si,
    output logic [W-1:0] nxt_o
);
    always_comb begin
        unique case (mode_e'(mode_i))
            MODE_HOLD: nxt_o = cur_i;
            MODE_LOAD: nxt_o = par_i;
            MODE_UP:   nxt_o = {cur_i[W-2:0], up_si};
            MODE_DOWN: nxt_o = {dn_si, cur_i[W-1:1]};
            default:   nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/ushift4.sv
module ushift4
    import ushift4_pkg::*;
(
    input  logic             clk_i,
    input  logic             clr_i,
    input  logic [1:0]       mode_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             up_si,
    input  logic             dn_si,
    output logic [WIDTH-1:0] q_o
);
    state_t           st_d, st_q;
    logic [WIDTH-1:0] nxt_w;

    ushift4_next #(.W(WIDTH)) u_next (
        .cur_i (st_q.word),
        .mode_i(mode_i),
        .par_i (par_i),
        .up_si (up_si),
        .dn_si (dn_si),
        .nxt_o (nxt_w)
    );

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.word = '0;
        else       st_d.word = nxt_w;
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign q_o = st_q.word;

    // checks against the port-level intent
    logic past_ok;
    always_ff @(posedge clk_i) past_ok <= 1'b1;

    AST_CLEAR_WINS: assert property (@(posedge clk_i) clr_i |=> (q_o == '0)); // R1
    AST_HOLD_KEEPS: assert property (@(posedge clk_i) disable iff (clr_i)
        (past_ok && mode_i == 2'b00) |=> $stable(q_o)); // R2
    AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (clr_i)
        (past_ok && mode_i == 2'b01) |=> (q_o == $past(par_i))); // R3
    AST_SHIFT_UP: assert property (@(posedge clk_i) disable iff (clr_i)
        (past_ok && mode_i == 2'b10) |=> (q_o == {$past(q_o[WIDTH-2:0]), $past(up_si)})); // R4
    AST_SHIFT_DOWN: assert property (@(posedge clk_i) disable iff (clr_i)
        (past_ok && mode_i == 2'b11) |=> (q_o == {$past(dn_si), $past(q_o[WIDTH-1:1])})); // R5
endmodule

// File: tb/sim_ushift4.sv
module sim_ushift4;
    logic       clk = 1'b0;
    logic       clr;
    logic [1:0] mode;
    logic [3:0] par;
    logic       usi, dsi;
    logic [3:0] q;
    int         n_run = 0;
    int         n_fail = 0;

    always #5 clk = ~clk;

    ushift4 u0 (.clk_i(clk), .clr_i(clr), .mode_i(mode), .par_i(par),
                .up_si(usi), .dn_si(dsi), .q_o(q));

    task automatic check(input logic [3:0] exp, input string req);
        n_run++;
        if (q !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, q, exp);
        end
    endtask

    task automatic step(input logic c, input logic [1:0] m, input logic [3:0] p,
                        input logic u, input logic d);
        clr = c; mode = m; par = p; usi = u; dsi = d;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got hang expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        clr = 1; mode = 0; par = 0; usi = 0; dsi = 0;
        @(negedge clk);
        step(1, 2'b01, 4'hF, 1, 1);
        check(4'h0, "R1 reset state");
        // worked examples
        step(0, 2'b01, 4'b0011, 0, 0); check(4'b0011, "R3 load 0011");
        step(0, 2'b01, 4'b0101, 1, 0); check(4'b0101, "R3 load example");
        step(0, 2'b01, 4'b0011, 0, 0);
        step(0, 2'b10, 4'b0101, 1, 0); check(4'b0111, "R4 up example");
        step(0, 2'b01, 4'b0011, 0, 0);
        step(0, 2'b11, 4'b0101, 1, 0); check(4'b0001, "R5 down example");
        // sweep: every start, mode, serial pair
        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 4; m++) begin
                for (int sp = 0; sp < 4; sp++) begin
                    logic [3:0] st, pv, ex;
                    logic u, d;
                    st = 4'(s); pv = ~st ^ 4'(sp); u = sp[0]; d = sp[1];
                    step(0, 2'b01, st, ~u, ~d);
                    check(st, "R3 sweep load");
                    case (m)
                        0: ex = st;
                        1: ex = pv;
                        2: ex = {st[2:0], u};
                        default: ex = {d, st[3:1]};
                    endcase
                    step(0, 2'(m), pv, u, d);
                    if (m == 0) check(ex, "R2 hold, R7 par ignored");
                    else if (m == 1) check(ex, "R3 load sweep");
                    else if (m == 2) check(ex, "R4 up sweep, R7 dn_si ignored");
                    else check(ex, "R5 down sweep, R7 up_si ignored");
                end
            end
        end
        // clear over every mode
        for (int m = 0; m < 4; m++) begin
            step(0, 2'b01, 4'hB, 0, 0);
            step(1, 2'(m), 4'hF, 1, 1);
            check(4'h0, "R1 clear priority");
        end
        // output changes only at the edge
        step(0, 2'b01, 4'h9, 0, 0);
        @(negedge clk);
        mode = 2'b01; par = 4'h6;
        #1 check(4'h9, "R6 no change before edge");
        @(posedge clk); #1 check(4'h6, "R6 visible after edge");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule